// File: doc/BRIEF.md
# Status Register Write-Protection Controller

This block holds the protection and mode bits of a serial flash status register and decides, for each request to rewrite that register, whether the write goes through. Software arms a write by pulsing the write-enable strobe. A later write request with a 16-bit value is then accepted or refused. The decision depends on a two-bit lock mode held in the register, the active-low protect pin and the quad-enable bit.

There are four lock modes. Software-only locking needs just the write-enable latch. Pin-controlled locking refuses every write while the protect pin is low. A third mode locks the register until the next power cycle, and that power cycle releases it by itself. The fourth mode locks the register permanently. The quad-enable bit tells the IO layer whether the protect and hold pins keep their function or serve as data lines 2 and 3. The command decoder, array programming and non-volatile write timing sit outside this block.

Top module: `srpc_top`

## Requirements
- R1: After reset, the register reads 0x0000 and both outcome pulses are low. The quad-mode flag and the hold flag are also low.
- R2: The lock mode is {bit 8, bit 7}. In mode 00 the protect pin is ignored, and a write is accepted exactly when the write-enable latch is set.
- R3: In mode 01, when the protect pin is low and bit 9 is 0, every write is refused.
- R4: In mode 01, when the protect pin is high, a write is accepted exactly when the write-enable latch is set.
- R5: In mode 10, every write is refused. A power-cycle event then forces bits 8 and 7 to 0.
- R6: In mode 11, every write is refused. A power-cycle event leaves the register unchanged.
- R7: Bit 9 is the quad-enable bit and drives `quad_mode_o`. When it is 1, the protect pin is treated as high and the hold input has no effect on `hold_o`. When it is 0, `hold_o` is the inverse of `hold_n_i`.
- R8: A power-cycle event keeps every register bit, except the forced release in mode 10. A write request in the same cycle as a power cycle is dropped with no outcome pulse.
- R9: The write-enable latch clears after every write attempt, whether it is accepted or refused. It also clears on a power cycle.
- R10: The cycle after a request, exactly one of `wr_ack_o` and `wr_nak_o` pulses for one cycle. An accepted value appears on `sr_o` in that same cycle. A refused write leaves `sr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wel_set_i | input | 1 | Arms the write-enable latch |
| wr_req_i | input | 1 | Write request strobe |
| wr_data_i | input | 16 | Value to write |
| wp_n_i | input | 1 | Active-low protect pin |
| hold_n_i | input | 1 | Active-low hold pin |
| pwr_cycle_i | input | 1 | Power-down/power-up event |
| sr_o | output | 16 | Register contents |
| wr_ack_o | output | 1 | Write accepted pulse |
| wr_nak_o | output | 1 | Write refused pulse |
| quad_mode_o | output | 1 | Pins 2/3 act as data lines |
| hold_o | output | 1 | Hold function asserted |

## Verification
Writes are tried both with and without the write-enable latch armed in each of the four lock modes. In mode 01 the protect pin is driven both low and high, which separates the pin gate from the latch gate. The protect pin is also driven low while quad-enable is set, which shows that the pin is overridden. Power cycles are applied in mode 10 and mode 11 with other bits set, which separates the self-releasing lock from the permanent one and shows that the other bits survive. A write is attempted without re-arming after a refusal, which shows that the latch clears on every attempt.

// File: rtl/srpc_pkg.sv
// Shared types for the status-register protection controller.
// Assumes the lock mode is formed as {upper protect bit, lower protect bit}.
package srpc_pkg;
    typedef enum logic [1:0] {
        LK_SOFT      = 2'b00,
        LK_PIN       = 2'b01,
        LK_UNTIL_PWR = 2'b10,
        LK_FOREVER   = 2'b11
    } lock_mode_e;
endpackage

// File: rtl/srpc_wel.sv
// Write-enable latch. It is armed by a strobe and cleared by any write attempt or power cycle.
// Assumes consume_i is high only in a cycle that carries a real write attempt.
module srpc_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic consume_i,
    input  logic pwr_i,
    output logic wel_o
);
    // Latch update: clearing wins over arming.
    always_ff @(posedge clk) begin
        if (!rst_n)                 wel_o <= 1'b0;
        else if (pwr_i || consume_i) wel_o <= 1'b0;
        else if (set_i)             wel_o <= 1'b1;
    end

    AST_WEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_i || pwr_i) |=> !wel_o); // R9
endmodule

// File: rtl/srpc_gate.sv
// Combinational write gate. It maps the lock mode, pin, quad-enable and latch to accept/refuse.
// Assumes a power-cycle event drops any concurrent request.
module srpc_gate
    import srpc_pkg::*;
(
    input  lock_mode_e mode_i,
    input  logic       wp_n_i,
    input  logic       qe_i,
    input  logic       wel_i,
    input  logic       req_i,
    input  logic       pwr_i,
    output logic       accept_o,
    output logic       refuse_o
);
    logic pin_high;
    logic mode_open;
    logic live_req;

    // Decide whether the current lock mode lets a write through.
    always_comb begin
        pin_high = qe_i | wp_n_i;
        live_req = req_i & ~pwr_i;
        unique case (mode_i)
            LK_SOFT:      mode_open = 1'b1;
            LK_PIN:       mode_open = pin_high;
            LK_UNTIL_PWR: mode_open = 1'b0;
            default:      mode_open = 1'b0;
        endcase
        accept_o = live_req & mode_open & wel_i;
        refuse_o = live_req & ~(mode_open & wel_i);
    end
endmodule

// File: rtl/srpc_store.sv
// Register storage and outcome pulses. It applies accepted writes and the power-cycle release.
// Assumes accept_i and refuse_i are never high together.
module srpc_store
    import srpc_pkg::*;
#(
    parameter int unsigned SR_W  = 16,
    parameter int unsigned POS_L = 7,
    parameter int unsigned POS_H = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept_i,
    input  logic            refuse_i,
    input  logic            pwr_i,
    input  logic [SR_W-1:0] data_i,
    output logic [SR_W-1:0] sr_o,
    output logic            ack_o,
    output logic            nak_o
);
    lock_mode_e mode_now;
    assign mode_now = lock_mode_e'({sr_o[POS_H], sr_o[POS_L]});

    // Register contents: a power cycle has priority, then an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_o <= '0;
        end else if (pwr_i) begin
            if (mode_now == LK_UNTIL_PWR) begin
                sr_o[POS_H] <= 1'b0;
                sr_o[POS_L] <= 1'b0;
            end
        end else if (accept_i) begin
            sr_o <= data_i;
        end
    end

    // One-cycle outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o <= 1'b0;
            nak_o <= 1'b0;
        end else begin
            ack_o <= accept_i;
            nak_o <= refuse_i;
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_o && nak_o)); // R10
    AST_NAK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        refuse_i |=> $stable(sr_o)); // R10
    AST_FOREVER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_now == LK_FOREVER) |=> (mode_now == LK_FOREVER)); // R6
    AST_PWR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_i && mode_now == LK_UNTIL_PWR) |=> (mode_now == LK_SOFT)); // R5
    AST_UNTIL_PWR_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_now == LK_UNTIL_PWR && !pwr_i) |=> !ack_o); // R5
endmodule

// File: rtl/srpc_top.sv
// Status register write-protection controller top level.
// Assumes the write strobe and the power-cycle event are single-cycle, synchronous pulses.
module srpc_top
    import srpc_pkg::*;
#(
    parameter int unsigned SR_W   = 16,
    parameter int unsigned POS_L  = 7,
    parameter int unsigned POS_H  = 8,
    parameter int unsigned POS_QE = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wel_set_i,
    input  logic            wr_req_i,
    input  logic [SR_W-1:0] wr_data_i,
    input  logic            wp_n_i,
    input  logic            hold_n_i,
    input  logic            pwr_cycle_i,
    output logic [SR_W-1:0] sr_o,
    output logic            wr_ack_o,
    output logic            wr_nak_o,
    output logic            quad_mode_o,
    output logic            hold_o
);
    logic       wel;
    logic       accept;
    logic       refuse;
    logic       qe;
    lock_mode_e mode;

    // Decode the stored fields that drive the gate and the pin function.
    always_comb begin
        qe          = sr_o[POS_QE];
        mode        = lock_mode_e'({sr_o[POS_H], sr_o[POS_L]});
        quad_mode_o = qe;
        hold_o      = ~qe & ~hold_n_i;
    end

    srpc_wel u_wel (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (wel_set_i),
        .consume_i (wr_req_i & ~pwr_cycle_i),
        .pwr_i     (pwr_cycle_i),
        .wel_o     (wel)
    );

    srpc_gate u_gate (
        .mode_i   (mode),
        .wp_n_i   (wp_n_i),
        .qe_i     (qe),
        .wel_i    (wel),
        .req_i    (wr_req_i),
        .pwr_i    (pwr_cycle_i),
        .accept_o (accept),
        .refuse_o (refuse)
    );

    srpc_store #(.SR_W(SR_W), .POS_L(POS_L), .POS_H(POS_H)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .refuse_i (refuse),
        .pwr_i    (pwr_cycle_i),
        .data_i   (wr_data_i),
        .sr_o     (sr_o),
        .ack_o    (wr_ack_o),
        .nak_o    (wr_nak_o)
    );

    AST_PIN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && !pwr_cycle_i && mode == LK_PIN && !wp_n_i && !qe) |=> wr_nak_o); // R3
    AST_NO_ARM_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && !wel) |=> !wr_ack_o); // R2
    AST_PWR_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_cycle_i |=> !(wr_ack_o || wr_nak_o)); // R8
endmodule

// File: tb/srpc_top_test.sv
// Scoreboard bench: the driver pushes expected outcomes and the monitor pops and compares them.
module srpc_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wel_set_i = 1'b0;
    logic        wr_req_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic        wp_n_i = 1'b1;
    logic        hold_n_i = 1'b1;
    logic        pwr_cycle_i = 1'b0;
    logic [15:0] sr_o;
    logic        wr_ack_o, wr_nak_o, quad_mode_o, hold_o;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic        ack;
        logic        nak;
        logic [15:0] sr;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    logic [15:0] m_sr  = '0;
    logic        m_wel = 1'b0;

    always #2.5 clk = ~clk;

    srpc_top uut (
        .clk(clk), .rst_n(rst_n), .wel_set_i(wel_set_i), .wr_req_i(wr_req_i),
        .wr_data_i(wr_data_i), .wp_n_i(wp_n_i), .hold_n_i(hold_n_i),
        .pwr_cycle_i(pwr_cycle_i), .sr_o(sr_o), .wr_ack_o(wr_ack_o),
        .wr_nak_o(wr_nak_o), .quad_mode_o(quad_mode_o), .hold_o(hold_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Monitor: compare the oldest expected outcome one cycle after its request.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.req, " ack"}, {15'b0, wr_ack_o}, {15'b0, e.ack});
            check({e.req, " nak"}, {15'b0, wr_nak_o}, {15'b0, e.nak});
            check({e.req, " sr"}, sr_o, e.sr);
        end
    end

    task automatic arm();
        @(negedge clk); wel_set_i = 1'b1;
        @(negedge clk); wel_set_i = 1'b0;
        m_wel = 1'b1;
    endtask

    // Driver: issue one write and push the outcome the requirements predict.
    task automatic do_write(input logic [15:0] v, input string req);
        exp_t e;
        logic open;
        logic [1:0] md;
        md = {m_sr[8], m_sr[7]};
        case (md)
            2'b00:   open = 1'b1;
            2'b01:   open = wp_n_i | m_sr[9];
            default: open = 1'b0;
        endcase
        e.ack = open & m_wel;
        e.nak = ~(open & m_wel);
        if (e.ack) m_sr = v;
        e.sr  = m_sr;
        e.req = req;
        m_wel = 1'b0;
        @(negedge clk); wr_req_i = 1'b1; wr_data_i = v;
        @(posedge clk); #1 exp_q.push_back(e);
        @(negedge clk); wr_req_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic power_cycle();
        @(negedge clk); pwr_cycle_i = 1'b1;
        @(negedge clk); pwr_cycle_i = 1'b0;
        if ({m_sr[8], m_sr[7]} == 2'b10) begin m_sr[8] = 1'b0; m_sr[7] = 1'b0; end
        m_wel = 1'b0;
    endtask

    initial begin : watchdog
        #200000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset sr", sr_o, 16'h0000);
        check("R1 reset outcome", {14'b0, wr_ack_o, wr_nak_o}, 16'h0);
        check("R1 reset quad/hold", {14'b0, quad_mode_o, hold_o}, 16'h0);

        do_write(16'h1234, "R2 unarmed in mode 00");
        wp_n_i = 1'b0;
        arm(); do_write(16'h0080, "R2 armed, pin low ignored in mode 00");

        arm(); do_write(16'h0000, "R3 pin low in mode 01");
        wp_n_i = 1'b1;
        do_write(16'h0000, "R9 latch cleared after refusal");
        arm(); do_write(16'h0280, "R4 pin high armed in mode 01");
        check("R7 quad flag set", {15'b0, quad_mode_o}, 16'h1);

        wp_n_i = 1'b0; hold_n_i = 1'b0;
        @(negedge clk);
        check("R7 hold ignored when quad", {15'b0, hold_o}, 16'h0);
        arm(); do_write(16'h0155, "R7 pin low overridden by quad");
        check("R7 hold active when not quad", {15'b0, hold_o}, 16'h1);
        hold_n_i = 1'b1; wp_n_i = 1'b1;

        arm(); do_write(16'h0000, "R5 mode 10 refuses");
        arm();
        power_cycle();
        @(negedge clk);
        check("R5 R8 power cycle releases mode 10, keeps bits", sr_o, 16'h0055);
        do_write(16'h0000, "R9 latch cleared by power cycle");

        // Request coinciding with a power cycle is dropped.
        arm();
        @(negedge clk); wr_req_i = 1'b1; pwr_cycle_i = 1'b1; wr_data_i = 16'hFFFF;
        @(negedge clk); wr_req_i = 1'b0; pwr_cycle_i = 1'b0;
        m_wel = 1'b0;
        check("R8 request with power cycle no outcome", {14'b0, wr_ack_o, wr_nak_o}, 16'h0);
        check("R8 request with power cycle no change", sr_o, 16'h0055);

        arm(); do_write(16'h0180, "R2 enter mode 11");
        arm(); do_write(16'h0000, "R6 mode 11 refuses");
        power_cycle();
        @(negedge clk);
        check("R6 power cycle keeps mode 11", sr_o, 16'h0180);
        arm(); do_write(16'h0000, "R6 still refused after power cycle");

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule